// File: doc/BRIEF.md
# CAN Controller Control Register and Bus-Off Recovery Sequencer

This block holds the 8-bit control word of a CAN protocol controller. The CPU reaches it through a small word bus with four addresses. It also guards CPU writes to the bit-timing word and merges protocol events into one module interrupt line. When the protocol engine reports bus-off, the block takes the controller off the bus by forcing the initialization bit. After the CPU releases that bit, the block keeps the controller off the bus until the receive line has shown 129 idle sequences. Each idle sequence is 11 consecutive recessive bit samples. The bit-stream engine supplies one sample per bit time, marked by a strobe.

The recovery sequencer is a three-state machine:
- S_RUN is normal operation.
- S_BOFF_WAIT means the block is in bus-off and Init is held.
- S_BOFF_COUNT means idle sequences are being counted.

The transitions are:
- enter_boff: S_RUN to S_BOFF_WAIT, on a bus-off pulse.
- release: S_BOFF_WAIT to S_BOFF_COUNT, once Init reads 0.
- recovered: S_BOFF_COUNT to S_RUN, on the strobe that completes the last idle sequence.

Word addresses are: 0 for control, 1 for status, 2 for bit timing. Address 3 reads as 0.

Top module: `can_ctrl_seq`

## Requirements
- R1: After reset, the control word reads 0x0001 (Init=1), and the status word and bit-timing word read 0. The outputs irq, bus_off_active and bus_enable are all 0.
- R2: A write to address 0 stores data bits 7..5 and 3..0. Reading address 0 returns those bits, with bit 4 and bits 15..8 always 0. The control bit positions are: bit0 Init, bit1 IE, bit2 SIE, bit3 EIE, bit5 DAR, bit6 CCE, bit7 Test.
- R3: A write to address 2 loads the bit-timing word only when CCE=1 and Init=1. Any other write to address 2 leaves the word unchanged.
- R4: A bus-off pulse in S_RUN sets Init. This overrides a CPU write of Init=0 in the same cycle. From the next cycle, bus_off_active=1 and bus_enable=0.
- R5: bus_enable is 1 only when Init=0 and the state is S_RUN. Once Init reads 0 in S_BOFF_WAIT, strobed samples are counted from the following cycle. rx_bit=1 means recessive. bus_off_active falls in the cycle after the strobe that completes 129 runs of 11 recessive samples.
- R6: A dominant sample restarts the current 11-sample run but keeps the count of completed runs. Cycles without bit_strobe are not counted.
- R7: Recovery cannot be shortened. Samples in S_BOFF_WAIT are not counted, writes to Init during S_BOFF_COUNT neither skip nor restart the count, and bus-off pulses outside S_RUN are ignored.
- R8: With EIE=1, three events set the error pending flag (status bit 0): an error-warning change pulse, a bus-off entry, and recovery completion. With EIE=0, these events leave the flag unchanged.
- R9: With SIE=1, a transfer-done pulse or a bus-error pulse sets the status pending flag (status bit 1). With SIE=0, these pulses leave the flag unchanged.
- R10: Writing 1 to status bit 0 or bit 1 clears that flag and no other. A set event in the same cycle as the clear wins. Status bit 2 reads bus_off_active.
- R11: irq is 1 when IE=1 and either pending flag is set. It is always 0 when IE=0.
- R12: no_auto_retx follows DAR and test_mode follows Test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Word address for both read and write |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data for cpu_addr (combinational) |
| ev_bus_off | input | 1 | Pulse: the protocol engine entered bus-off |
| ev_warn_chg | input | 1 | Pulse: the error-warning status changed |
| ev_tx_done | input | 1 | Pulse: a message transfer completed |
| ev_bus_err | input | 1 | Pulse: a bus error was detected |
| bit_strobe | input | 1 | One cycle per bit time; rx_bit is valid |
| rx_bit | input | 1 | Sampled receive line, 1 = recessive |
| bt_cfg | output | 16 | Bit-timing word |
| bus_enable | output | 1 | The protocol engine may take part in bus traffic |
| bus_off_active | output | 1 | Bus-off, from entry until recovery completes |
| no_auto_retx | output | 1 | Automatic retransmission disabled |
| test_mode | output | 1 | Test mode selected |
| irq | output | 1 | Module interrupt request |

## Verification
All 256 control-word values are written and read back. This separates the writable bits from the reserved bit, and shows that the DAR and Test outputs track their bits. The four CCE/Init combinations are applied against bit-timing writes, so a protection that looks at only one of the two bits is caught. Every combination of the three enable bits is crossed with each interrupt event, which shows up wrong flag routing and wrong gating of irq. Recovery runs are sampled one strobe before and exactly at the expected completion. The runs include:
- recessive samples taken in S_BOFF_WAIT;
- a dominant sample in mid-sequence, and one at the last position of a run;
- Init toggling and a stray bus-off pulse during counting.

Each of these moves the completion point if handled wrongly.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;

    typedef enum logic [1:0] {
        S_RUN        = 2'd0,
        S_BOFF_WAIT  = 2'd1,
        S_BOFF_COUNT = 2'd2
    } boff_state_e;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int CTL_INIT = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_SIE  = 2;
    localparam int CTL_EIE  = 3;
    localparam int CTL_DAR  = 5;
    localparam int CTL_CCE  = 6;
    localparam int CTL_TEST = 7;

    localparam logic [7:0] CTL_RW_MASK = 8'hEF;
    localparam logic [7:0] CTL_RESET   = 8'h01;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_BT   = 2'd2;

endpackage

// File: rtl/can_idle_counter.sv
module can_idle_counter #(
    parameter int RUN_LEN = 11,
    parameter int SEQ_CNT = 129
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic bit_strobe,
    input  logic rx_recessive,
    output logic seq_all_done
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam int SEQ_W = $clog2(SEQ_CNT);

    logic [RUN_W-1:0] run_q;
    logic [SEQ_W-1:0] seq_q;
    logic             run_last;
    logic             seq_last;
    logic             take;

    assign run_last     = (run_q == RUN_W'(RUN_LEN - 1));
    assign seq_last     = (seq_q == SEQ_W'(SEQ_CNT - 1));
    assign take         = count_en && bit_strobe;
    assign seq_all_done = take && rx_recessive && run_last && seq_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            seq_q <= '0;
        end else if (clear) begin
            run_q <= '0;
            seq_q <= '0;
        end else if (take) begin
            if (!rx_recessive) begin
                run_q <= '0;
            end else if (run_last) begin
                run_q <= '0;
                seq_q <= seq_last ? '0 : seq_q + SEQ_W'(1);
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_LEN - 1));

    assert_dominant_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && take && !rx_recessive) |=> (run_q == '0));

    assert_dominant_keeps_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && take && !rx_recessive) |=> $stable(seq_q));

    assert_no_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !bit_strobe) |=> ($stable(seq_q) && $stable(run_q)));

endmodule

// File: rtl/can_irq_merge.sv
module can_irq_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic stat_evt,
    input  logic err_en,
    input  logic stat_en,
    input  logic irq_en,
    input  logic clr_err,
    input  logic clr_stat,
    output logic err_pend,
    output logic stat_pend,
    output logic irq
);
    logic err_set;
    logic stat_set;

    assign err_set  = err_evt && err_en;
    assign stat_set = stat_evt && stat_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pend  <= 1'b0;
            stat_pend <= 1'b0;
        end else begin
            err_pend  <= err_set  || (err_pend  && !clr_err);
            stat_pend <= stat_set || (stat_pend && !clr_stat);
        end
    end

    assign irq = irq_en && (err_pend || stat_pend);

    assert_err_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_pend);

    assert_stat_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set |=> stat_pend);

    assert_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en && !err_pend) |=> !err_pend);

    assert_stat_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_en && !stat_pend) |=> !stat_pend);

endmodule

// File: rtl/can_ctrl_seq.sv
module can_ctrl_seq
    import can_ctrl_pkg::*;
#(
    parameter int RUN_LEN = 11,
    parameter int SEQ_CNT = 129,
    parameter int BT_W    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    input  logic        ev_bus_off,
    input  logic        ev_warn_chg,
    input  logic        ev_tx_done,
    input  logic        ev_bus_err,
    input  logic        bit_strobe,
    input  logic        rx_bit,
    output logic [15:0] bt_cfg,
    output logic        bus_enable,
    output logic        bus_off_active,
    output logic        no_auto_retx,
    output logic        test_mode,
    output logic        irq
);
    boff_state_e     state_q;
    boff_state_e     state_d;
    logic [7:0]      ctrl_q;
    logic [BT_W-1:0] bt_q;
    logic            wr_ctrl;
    logic            wr_stat;
    logic            wr_bt;
    logic            boff_entry;
    logic            seq_done;
    logic            cnt_en;
    logic            cnt_clear;
    logic            err_pend;
    logic            stat_pend;
    logic            err_evt;
    logic            stat_evt;

    assign wr_ctrl    = cpu_we && (cpu_addr == ADR_CTRL);
    assign wr_stat    = cpu_we && (cpu_addr == ADR_STAT);
    assign wr_bt      = cpu_we && (cpu_addr == ADR_BT);
    assign boff_entry = ev_bus_off && (state_q == S_RUN);

    // Control word; a bus-off entry overrides the CPU on Init
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTL_RESET;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= cpu_wdata[7:0] & CTL_RW_MASK;
            end
            if (boff_entry) begin
                ctrl_q[CTL_INIT] <= 1'b1;
            end
        end
    end

    // Bit-timing word, writable only with CCE and Init both set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '0;
        end else if (wr_bt && ctrl_q[CTL_CCE] && ctrl_q[CTL_INIT]) begin
            bt_q <= cpu_wdata[BT_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:        if (ev_bus_off)        state_d = S_BOFF_WAIT;
            S_BOFF_WAIT:  if (!ctrl_q[CTL_INIT]) state_d = S_BOFF_COUNT;
            S_BOFF_COUNT: if (seq_done)          state_d = S_RUN;
            default:                             state_d = S_RUN;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        bus_off_active = 1'b1;
        cnt_en         = 1'b0;
        cnt_clear      = 1'b1;
        unique case (state_q)
            S_RUN:        bus_off_active = 1'b0;
            S_BOFF_WAIT:  bus_off_active = 1'b1;
            S_BOFF_COUNT: begin
                cnt_en    = 1'b1;
                cnt_clear = 1'b0;
            end
            default:      bus_off_active = 1'b1;
        endcase
    end

    assign bus_enable   = !ctrl_q[CTL_INIT] && !bus_off_active;
    assign no_auto_retx = ctrl_q[CTL_DAR];
    assign test_mode    = ctrl_q[CTL_TEST];
    assign bt_cfg       = 16'(bt_q);

    can_idle_counter #(
        .RUN_LEN (RUN_LEN),
        .SEQ_CNT (SEQ_CNT)
    ) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (cnt_clear),
        .count_en     (cnt_en),
        .bit_strobe   (bit_strobe),
        .rx_recessive (rx_bit),
        .seq_all_done (seq_done)
    );

    assign err_evt  = ev_warn_chg || boff_entry || seq_done;
    assign stat_evt = ev_tx_done || ev_bus_err;

    can_irq_merge u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_evt   (err_evt),
        .stat_evt  (stat_evt),
        .err_en    (ctrl_q[CTL_EIE]),
        .stat_en   (ctrl_q[CTL_SIE]),
        .irq_en    (ctrl_q[CTL_IE]),
        .clr_err   (wr_stat && cpu_wdata[0]),
        .clr_stat  (wr_stat && cpu_wdata[1]),
        .err_pend  (err_pend),
        .stat_pend (stat_pend),
        .irq       (irq)
    );

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            ADR_CTRL: cpu_rdata[7:0] = ctrl_q;
            ADR_STAT: cpu_rdata[2:0] = {bus_off_active, stat_pend, err_pend};
            ADR_BT:   cpu_rdata      = 16'(bt_q);
            default:  cpu_rdata      = '0;
        endcase
    end

    assert_boff_forces_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        boff_entry |=> (ctrl_q[CTL_INIT] && bus_off_active));

    assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_active |-> !bus_enable);

    assert_bt_protect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_bt && ctrl_q[CTL_CCE] && ctrl_q[CTL_INIT]) |=> $stable(bt_q));

    assert_no_early_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BOFF_COUNT && !seq_done) |=> (state_q == S_BOFF_COUNT));

    assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BOFF_WAIT && ctrl_q[CTL_INIT]) |=> (state_q == S_BOFF_WAIT));

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CTL_IE] |-> !irq);

endmodule

// File: tb/can_ctrl_seq_bench.sv
module can_ctrl_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LEN    = 11;
    localparam int SEQ_CNT    = 129;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;
    logic        ev_bus_off = 1'b0;
    logic        ev_warn_chg = 1'b0;
    logic        ev_tx_done = 1'b0;
    logic        ev_bus_err = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        rx_bit = 1'b1;
    logic [15:0] bt_cfg;
    logic        bus_enable;
    logic        bus_off_active;
    logic        no_auto_retx;
    logic        test_mode;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_ctrl_seq u_can_ctrl_seq (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ev_bus_off(ev_bus_off),
        .ev_warn_chg(ev_warn_chg), .ev_tx_done(ev_tx_done), .ev_bus_err(ev_bus_err),
        .bit_strobe(bit_strobe), .rx_bit(rx_bit), .bt_cfg(bt_cfg),
        .bus_enable(bus_enable), .bus_off_active(bus_off_active),
        .no_auto_retx(no_auto_retx), .test_mode(test_mode), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        cpu_addr = a;
        #1;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: ev_warn_chg = 1'b1;
            1: ev_tx_done  = 1'b1;
            2: ev_bus_err  = 1'b1;
            default: ev_bus_off = 1'b1;
        endcase
        @(negedge clk);
        ev_warn_chg = 1'b0; ev_tx_done = 1'b0; ev_bus_err = 1'b0; ev_bus_off = 1'b0;
    endtask

    task automatic send_bit(input logic r);
        bit_strobe = 1'b1; rx_bit = r;
        @(negedge clk);
        bit_strobe = 1'b0; rx_bit = 1'b1;
    endtask

    task automatic send_rec(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [15:0] bt_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0); chk("R1 ctrl", cpu_rdata, 16'h0001);
        rd(2'd1); chk("R1 status", cpu_rdata, 16'h0000);
        rd(2'd2); chk("R1 bt", cpu_rdata, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 bus_off", {15'd0, bus_off_active}, 16'd0);
        chk("R1 bus_enable", {15'd0, bus_enable}, 16'd0);

        // R2 / R12 / R5: full sweep of the control byte
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, {8'hA5, 8'(v)});
            rd(2'd0);
            chk("R2 ctrl readback", cpu_rdata, {8'h00, 8'(v) & 8'hEF});
            chk("R12 no_auto_retx", {15'd0, no_auto_retx}, {15'd0, 1'(v >> 5)});
            chk("R12 test_mode", {15'd0, test_mode}, {15'd0, 1'(v >> 7)});
            chk("R5 bus_enable", {15'd0, bus_enable}, {15'd0, ~1'(v)});
        end

        // R3: bit-timing protection under all CCE/Init combinations
        bt_exp = 16'h0000;
        for (int c = 0; c < 4; c++) begin
            wr(2'd0, {8'h00, 1'b0, 1'(c >> 1), 5'd0, 1'(c)});
            wr(2'd2, 16'h1357 + 16'(c) * 16'h1111);
            if (c == 3) bt_exp = 16'h1357 + 16'(c) * 16'h1111;
            rd(2'd2);
            chk("R3 bt readback", cpu_rdata, bt_exp);
            chk("R3 bt_cfg", bt_cfg, bt_exp);
        end

        // R8 / R9 / R11: enable combinations crossed with events
        for (int e = 0; e < 8; e++) begin
            for (int k = 0; k < 3; k++) begin
                logic ie, sie, eie, xe, xs;
                ie = 1'(e); sie = 1'(e >> 1); eie = 1'(e >> 2);
                wr(2'd0, {12'd0, eie, sie, ie, 1'b0});
                wr(2'd1, 16'h0003);
                pulse(k);
                xe = (k == 0) && eie;
                xs = (k != 0) && sie;
                rd(2'd1);
                chk(k == 0 ? "R8 err pending" : "R9 status pending", cpu_rdata, {14'd0, xs, xe});
                chk("R11 irq", {15'd0, irq}, {15'd0, ie & (xe | xs)});
            end
        end

        // R10: selective clear and set-wins
        wr(2'd0, 16'h000E);
        pulse(0); pulse(1);
        wr(2'd1, 16'h0001);
        rd(2'd1); chk("R10 clear err only", cpu_rdata, 16'h0002);
        wr(2'd1, 16'h0002);
        rd(2'd1); chk("R10 clear stat", cpu_rdata, 16'h0000);
        chk("R10 irq low after clear", {15'd0, irq}, 16'd0);
        cpu_we = 1'b1; cpu_addr = 2'd1; cpu_wdata = 16'h0001; ev_warn_chg = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; ev_warn_chg = 1'b0;
        rd(2'd1); chk("R10 set wins", cpu_rdata, 16'h0001);
        wr(2'd1, 16'h0003);

        // R4: bus-off entry beats a simultaneous Init clear
        wr(2'd0, 16'h000A);
        chk("R5 bus_enable on", {15'd0, bus_enable}, 16'd1);
        cpu_we = 1'b1; cpu_addr = 2'd0; cpu_wdata = 16'h000A; ev_bus_off = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; ev_bus_off = 1'b0;
        rd(2'd0); chk("R4 init forced", cpu_rdata, 16'h000B);
        chk("R4 bus_off_active", {15'd0, bus_off_active}, 16'd1);
        chk("R4 bus_enable off", {15'd0, bus_enable}, 16'd0);
        rd(2'd1); chk("R8 boff entry pending", cpu_rdata, 16'h0005);
        chk("R11 irq boff", {15'd0, irq}, 16'd1);
        wr(2'd1, 16'h0001);

        // R7: samples while Init is held are not counted
        send_rec(30);
        wr(2'd0, 16'h000A);
        @(negedge clk);
        // R6: 50 runs, then a dominant mid-run
        send_rec(50 * RUN_LEN + 4);
        send_bit(1'b0);
        // R7: Init toggled and stray bus-off during counting
        wr(2'd0, 16'h000B);
        wr(2'd0, 16'h000A);
        pulse(3);
        rd(2'd1); chk("R7 stray boff ignored", cpu_rdata, 16'h0004);
        rd(2'd0); chk("R7 init readback", cpu_rdata, 16'h000A);
        send_rec((SEQ_CNT - 50) * RUN_LEN - 1);
        chk("R6 one strobe short", {15'd0, bus_off_active}, 16'd1);
        chk("R5 still quiet", {15'd0, bus_enable}, 16'd0);
        send_bit(1'b1);
        chk("R5 recovered", {15'd0, bus_off_active}, 16'd0);
        chk("R5 bus_enable back", {15'd0, bus_enable}, 16'd1);
        rd(2'd1); chk("R8 recovery pending", cpu_rdata, 16'h0001);
        chk("R11 irq recovery", {15'd0, irq}, 16'd1);
        wr(2'd1, 16'h0003);

        // R6 / R8: dominant at last run position, EIE off
        wr(2'd0, 16'h0002);
        pulse(3);
        wr(2'd0, 16'h0002);
        @(negedge clk);
        send_rec(RUN_LEN - 1);
        send_bit(1'b0);
        send_rec(SEQ_CNT * RUN_LEN - 1);
        chk("R6 dominant last slot", {15'd0, bus_off_active}, 16'd1);
        send_bit(1'b1);
        chk("R5 second recovery", {15'd0, bus_off_active}, 16'd0);
        rd(2'd1); chk("R8 EIE off no pending", cpu_rdata, 16'h0000);
        chk("R11 irq idle", {15'd0, irq}, 16'd0);

        summary();
    end
endmodule